// File: doc/BRIEF.md
# Per-CPU Soft Interrupt Register

This block keeps the 32-bit interrupt pending word for one processor. Software reaches it through a small register port addressed by word. One word reads the pending word. One word clears bits when ones are written to it. One word sets bits when ones are written to it. Software can change only the upper fifteen bits, 31 down to 17. Those bits are the software-requested processor interrupt levels 1 to 15.

Hardware sources that already carry a processor interrupt level can set or clear the matching low bit of the pending word through two dedicated request inputs. The block also drives a 16-entry vector of software-requested levels, taken from the upper half of the pending word.

The clear word has a compatibility quirk. If bit 14 of the written data is set, bit 31 is also cleared. The alias is added before the software mask is applied.

Top module: `cpu_softint_reg`

## Requirements
- R1: After reset the pending word is zero, and the level vector `softLevels` is zero.
- R2: A read (`regValid`=1, `regWrite`=0) returns the pending word on `regRdata` in the same cycle when `regAddr`=0. It returns zero for addresses 1, 2 and 3, and also when `regValid` is low.
- R3: A write to address 1 clears each pending bit whose data bit is one. Only bits 31..17 (mask 0xFFFE0000) can be cleared this way. Bits 16..0 are never changed by it.
- R4: For a write to address 1 with data bit 14 set, bit 31 of the pending word is also cleared, even when data bit 31 is zero.
- R5: A write to address 2 ORs (data AND 0xFFFE0000) into the pending word. Data bits 16..0 are ignored.
- R6: `softLevels[k]` equals pending bit k+16 for k = 1..15, and `softLevels[0]` is always 0.
- R7: A pulse on `hwSetValid` with level p (0..15) sets pending bit p from the next cycle onward.
- R8: A pulse on `hwClrValid` with level p clears pending bit p from the next cycle onward. When set and clear name the same level in one cycle, the clear wins.
- R9: Writes to addresses 0 and 3 leave the pending word unchanged.
- R10: A hardware request and a software write in the same cycle both take effect. The software write is applied after the hardware update.
- R11: All updates take effect at the clock edge. A read in the same cycle as an update returns the value held before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regValid | input | 1 | Register access strobe |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 2 | Word address: 0 = pending, 1 = clear, 2 = set, 3 = unused |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid in the access cycle |
| hwSetValid | input | 1 | Hardware set request |
| hwSetLevel | input | 4 | Level whose pending bit is set |
| hwClrValid | input | 1 | Hardware clear request |
| hwClrLevel | input | 4 | Level whose pending bit is cleared |
| softLevels | output | 16 | Software-requested level vector |

## Verification
The set word is written with all ones, to show that the low seventeen bits cannot be reached. The clear word is written with single bits, with all ones, and with only bit 14. Together these separate a correct mask from a missing mask, and the alias from a plain clear of bit 14. Hardware pulses are placed on levels that software also owns, and on a level named by set and clear at once, to show the clear-wins rule. Mixed cycles, where a hardware pulse arrives together with a software write or a read, separate a correct same-cycle merge from a lost update or a read that already shows the new value.

// File: rtl/softint_pkg.sv
package softint_pkg;
  // strobes decoded from the register port, one per action
  typedef struct packed {
    logic rdPend;
    logic wrClr;
    logic wrSet;
  } regStrobe_t;
endpackage

// File: rtl/softint_ctrl.sv
module softint_ctrl
  import softint_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int WORD_PND = 0,
  parameter int WORD_CLR = 1,
  parameter int WORD_SET = 2
) (
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strobe
);
  always_comb begin
    strobe        = '0;
    strobe.rdPend = regValid && !regWrite && (regAddr == ADDR_W'(WORD_PND));
    strobe.wrClr  = regValid &&  regWrite && (regAddr == ADDR_W'(WORD_CLR));
    strobe.wrSet  = regValid &&  regWrite && (regAddr == ADDR_W'(WORD_SET));
  end
endmodule

// File: rtl/softint_datapath.sv
module softint_datapath
  import softint_pkg::*;
#(
  parameter int                 DATA_W    = 32,
  parameter int                 LEVEL_W   = 4,
  parameter logic [DATA_W-1:0]  SOFT_MASK = 32'hFFFE_0000,
  parameter int                 ALIAS_SRC = 14,
  parameter int                 ALIAS_DST = 31,
  localparam int                NUM_LVL   = 1 << LEVEL_W,
  localparam int                LVL_SHIFT = DATA_W - NUM_LVL
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strobe,
  input  logic [DATA_W-1:0]  regWdata,
  input  logic               hwSetValid,
  input  logic [LEVEL_W-1:0] hwSetLevel,
  input  logic               hwClrValid,
  input  logic [LEVEL_W-1:0] hwClrLevel,
  output logic [DATA_W-1:0]  pendWord,
  output logic [DATA_W-1:0]  regRdata,
  output logic [NUM_LVL-1:0] softLevels
);
  logic [DATA_W-1:0] hwSetVec, hwClrVec;
  logic [DATA_W-1:0] aliasVec, swClrVec, swSetVec;
  logic [DATA_W-1:0] afterHw, pendNext;

  // one-hot decode of the level-encoded hardware requests
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i < NUM_LVL) begin : g_lvl
      assign hwSetVec[i] = hwSetValid && (hwSetLevel == LEVEL_W'(i));
      assign hwClrVec[i] = hwClrValid && (hwClrLevel == LEVEL_W'(i));
    end else begin : g_none
      assign hwSetVec[i] = 1'b0;
      assign hwClrVec[i] = 1'b0;
    end
  end

  always_comb begin
    aliasVec            = '0;
    aliasVec[ALIAS_DST] = regWdata[ALIAS_SRC];
    // alias is merged before masking
    swClrVec = strobe.wrClr ? ((regWdata | aliasVec) & SOFT_MASK) : '0;
    swSetVec = strobe.wrSet ? (regWdata & SOFT_MASK) : '0;
    // hardware first (clear wins over set), software on top
    afterHw  = (pendWord | hwSetVec) & ~hwClrVec;
    pendNext = (afterHw & ~swClrVec) | swSetVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendWord <= '0;
    else       pendWord <= pendNext;
  end

  assign regRdata   = strobe.rdPend ? pendWord : '0;
  assign softLevels = NUM_LVL'((pendWord & SOFT_MASK) >> LVL_SHIFT);
endmodule

// File: rtl/cpu_softint_reg.sv
module cpu_softint_reg
  import softint_pkg::*;
#(
  parameter int                 DATA_W    = 32,
  parameter int                 ADDR_W    = 2,
  parameter int                 LEVEL_W   = 4,
  parameter logic [DATA_W-1:0]  SOFT_MASK = 32'hFFFE_0000,
  parameter int                 ALIAS_SRC = 14,
  parameter int                 ALIAS_DST = 31,
  localparam int                NUM_LVL   = 1 << LEVEL_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regValid,
  input  logic               regWrite,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  logic               hwSetValid,
  input  logic [LEVEL_W-1:0] hwSetLevel,
  input  logic               hwClrValid,
  input  logic [LEVEL_W-1:0] hwClrLevel,
  output logic [NUM_LVL-1:0] softLevels
);
  regStrobe_t        strobe;
  logic [DATA_W-1:0] pendWord;

  softint_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regValid (regValid),
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .strobe   (strobe)
  );

  softint_datapath #(
    .DATA_W(DATA_W), .LEVEL_W(LEVEL_W), .SOFT_MASK(SOFT_MASK),
    .ALIAS_SRC(ALIAS_SRC), .ALIAS_DST(ALIAS_DST)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .regWdata   (regWdata),
    .hwSetValid (hwSetValid),
    .hwSetLevel (hwSetLevel),
    .hwClrValid (hwClrValid),
    .hwClrLevel (hwClrLevel),
    .pendWord   (pendWord),
    .regRdata   (regRdata),
    .softLevels (softLevels)
  );
endmodule

// File: rtl/softint_checker.sv
module softint_checker #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2,
  parameter int LEVEL_W   = 4,
  parameter logic [DATA_W-1:0] SOFT_MASK = 32'hFFFE_0000,
  localparam int NUM_LVL  = 1 << LEVEL_W
) (
  input logic               clk,
  input logic               rstN,
  input logic               regValid,
  input logic               regWrite,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [DATA_W-1:0]  regWdata,
  input logic [DATA_W-1:0]  regRdata,
  input logic               hwSetValid,
  input logic [LEVEL_W-1:0] hwSetLevel,
  input logic               hwClrValid,
  input logic [LEVEL_W-1:0] hwClrLevel,
  input logic [NUM_LVL-1:0] softLevels,
  input logic [DATA_W-1:0]  pendWord
);
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && !regWrite && regAddr != '0) |-> (regRdata == '0)); // R2

  AST_SET_WORD_OR: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && regWrite && regAddr == ADDR_W'(2))
    |=> ((pendWord & $past(regWdata & SOFT_MASK)) == $past(regWdata & SOFT_MASK))); // R5

  AST_ALIAS_CLEARS_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && regWrite && regAddr == ADDR_W'(1) && regWdata[14]) |=> !pendWord[31]); // R4

  AST_CLR_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && regWrite && regAddr == ADDR_W'(1) && !hwSetValid && !hwClrValid)
    |=> $stable(pendWord[16:0])); // R3

  AST_LEVEL_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    softLevels[0] == 1'b0); // R6

  AST_IGNORED_WORDS: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && regWrite && (regAddr == ADDR_W'(0) || regAddr == ADDR_W'(3))
     && !hwSetValid && !hwClrValid) |=> $stable(pendWord)); // R9

  AST_HW_SET_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    (hwSetValid && !(hwClrValid && hwClrLevel == hwSetLevel))
    |=> pendWord[$past(hwSetLevel)]); // R7

  AST_HW_CLR_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    hwClrValid |=> !pendWord[$past(hwClrLevel)]); // R8
endmodule

bind cpu_softint_reg softint_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEVEL_W(LEVEL_W), .SOFT_MASK(SOFT_MASK)
) u_chk (.*);

// File: tb/cpu_softint_reg_test.sv
module cpu_softint_reg_test;
  localparam logic [31:0] MASK = 32'hFFFE_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regValid = 1'b0, regWrite = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        hwSetValid = 1'b0, hwClrValid = 1'b0;
  logic [3:0]  hwSetLevel = '0, hwClrLevel = '0;
  logic [15:0] softLevels;

  int checks = 0;
  int errors = 0;
  logic [31:0] model = '0;

  typedef struct {
    logic [31:0] rd;
    logic [15:0] lv;
    string       tag;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk; // 125 MHz

  cpu_softint_reg uut (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .hwSetValid(hwSetValid), .hwSetLevel(hwSetLevel),
    .hwClrValid(hwClrValid), .hwClrLevel(hwClrLevel), .softLevels(softLevels)
  );

  // one operation per cycle, driven at the falling edge
  task automatic op(input logic v, input logic w, input logic [1:0] a,
                    input logic [31:0] d, input logic sE, input logic [3:0] sL,
                    input logic cE, input logic [3:0] cL, input string tag);
    logic [31:0] clr;
    item_t it;
    @(negedge clk);
    regValid = v; regWrite = w; regAddr = a; regWdata = d;
    hwSetValid = sE; hwSetLevel = sL; hwClrValid = cE; hwClrLevel = cL;
    if (v && !w) begin
      it.rd  = (a == 2'd0) ? model : 32'h0;
      it.lv  = {model[31:17], 1'b0};
      it.tag = tag;
      sb.push_back(it);
    end
    if (sE) model[sL] = 1'b1;
    if (cE) model[cL] = 1'b0;
    if (v && w && a == 2'd1) begin
      clr = d | (d[14] ? 32'h8000_0000 : 32'h0);
      model = model & ~(clr & MASK);
    end
    if (v && w && a == 2'd2) model = model | (d & MASK);
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    op(1'b1, 1'b0, a, 32'h0, 1'b0, 4'd0, 1'b0, 4'd0, tag);
  endtask
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    op(1'b1, 1'b1, a, d, 1'b0, 4'd0, 1'b0, 4'd0, "");
  endtask
  task automatic hw(input logic sE, input logic [3:0] sL,
                    input logic cE, input logic [3:0] cL);
    op(1'b0, 1'b0, 2'd0, 32'h0, sE, sL, cE, cL, "");
  endtask

  // monitor: compares each read against the scoreboard
  always @(negedge clk) begin
    #2;
    if (rstN && regValid && !regWrite) begin
      item_t it;
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty: act=%h exp=none", regRdata);
      end else begin
        it = sb.pop_front();
        if (regRdata !== it.rd || softLevels !== it.lv) begin
          errors++;
          $display("FAIL %s: act rdata=%h levels=%h exp rdata=%h levels=%h",
                   it.tag, regRdata, softLevels, it.rd, it.lv);
        end
      end
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired: act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    rd(2'd0, "R1 reset pending and levels zero");
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd0, "R5 R6 set word masked, levels mapped");
    wr(2'd1, 32'h0002_0000);
    rd(2'd0, "R3 single bit clear");
    hw(1'b1, 4'd3, 1'b0, 4'd0);
    hw(1'b1, 4'd15, 1'b0, 4'd0);
    rd(2'd0, "R7 hardware set levels 3 and 15");
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd0, "R3 clear all keeps low bits");
    wr(2'd2, 32'h8000_0000);
    rd(2'd0, "R6 bit31 shows as level 15");
    wr(2'd1, 32'h0000_4000);
    rd(2'd0, "R4 alias clears bit31");
    wr(2'd2, 32'h0001_FFFF);
    rd(2'd0, "R5 low data bits ignored");
    hw(1'b0, 4'd0, 1'b1, 4'd3);
    rd(2'd0, "R8 hardware clear level 3");
    hw(1'b1, 4'd5, 1'b1, 4'd5);
    rd(2'd0, "R8 same level set and clear, clear wins");
    wr(2'd2, 32'h0024_0000);
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd0, "R9 writes to words 0 and 3 ignored");
    rd(2'd1, "R2 read word 1 is zero");
    rd(2'd2, "R2 read word 2 is zero");
    rd(2'd3, "R2 read word 3 is zero");
    op(1'b1, 1'b1, 2'd2, 32'h0010_0000, 1'b1, 4'd7, 1'b0, 4'd0, "");
    rd(2'd0, "R10 hardware set with software set");
    op(1'b1, 1'b1, 2'd1, 32'h0004_0000, 1'b0, 4'd0, 1'b1, 4'd15, "");
    rd(2'd0, "R10 hardware clear with software clear");
    op(1'b1, 1'b0, 2'd0, 32'h0, 1'b1, 4'd9, 1'b0, 4'd0, "R11 read returns pre-update value");
    rd(2'd0, "R11 update visible next cycle");
    op(1'b0, 1'b0, 2'd0, 32'h0, 1'b0, 4'd0, 1'b0, 4'd0, "");
    @(negedge clk);
    #3;
    if (sb.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL scoreboard leftover: act=%0d exp=0", sb.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule